// File: doc/BRIEF.md
# Headphone Amplifier Command Register Slave

This block is the serial control port of a stereo headphone amplifier. It watches a two-wire (I2C-compatible) bus, oversampling SCL and SDA with a fast system clock, and accepts a single 8-bit command byte written to one of two selectable 7-bit addresses. It acknowledges valid writes by asserting an open-drain pull-down enable on SDA. The block never drives SDA high.

A received command byte is parked in a pending holder. It reaches the live control register only when the master closes the transfer with a STOP. The live register is split into decoded control outputs: an amplifier-on bit, a bass-boost enable, a gain-range select and a 5-bit volume code. A combined device-enable output is formed from the register's on bit and an active-low external shutdown pin. The serial port stays fully working while the device is shut down, so software can set up volume and modes before switching the amplifier on.

Top module: `hp_cmd_slave`

## Requirements
- R1: After synchronous reset the command register holds 0xFF, so the on, bass and range outputs are 1 and the volume is 31. SDA is released, and no commit strobe has been seen.
- R2: The slave answers address 1001100 when `addr_sel` is 0 and 1001101 when it is 1. On a match with R/W = 0 (address byte sent MSB first, R/W in the last bit), it pulls SDA low during the ninth clock.
- R3: An address mismatch or a read request (R/W = 1) is NACKed. The slave then stays silent and leaves the register unchanged until the next START.
- R4: The first data byte after a matched address is ACKed. The register changes only when the following STOP is seen, and `commit` pulses high for exactly one clock in the cycle the register updates.
- R5: Command byte fields: bit 7 drives `amp_on`, bit 6 drives `bass_en`, bit 5 drives `range_hi`, and bits 4:0 drive `volume`. Volume code 00000 is mute.
- R6: `dev_enable` is high only when `shdn_n` is high and register bit 7 is 1.
- R7: Writes made while `shdn_n` is low, or while bit 7 is 0, are accepted and stored.
- R8: A STOP or a repeated START that arrives before all 8 data bits are in discards the partial byte, and the register keeps its old value.
- R9: Any data byte after the first in one transfer is NACKed and not stored. The first byte is still committed at STOP.
- R10: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks is ignored.
- R11: A repeated START discards any byte pending from earlier in the same transfer. Only a byte received after the last START commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Selects address LSB (0: 1001100, 1: 1001101) |
| shdn_n | input | 1 | External shutdown pin, low = shut down |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| amp_on | output | 1 | Register bit 7 |
| bass_en | output | 1 | Register bit 6 |
| range_hi | output | 1 | Register bit 5 |
| volume | output | 5 | Register bits 4:0, 0 = mute |
| dev_enable | output | 1 | Combined device enable |
| commit | output | 1 | One-cycle strobe on register update |

## Verification
A wrong bit counter or a wrong state in the transfer engine shows at the pins within one serial clock. The ACK pull-down appears on the wrong clock or not at all, and the bench samples it in the ninth high phase of each byte. A pending holder that commits too early or never shows as a register change without a following STOP, or a missing one after STOP. The bench checks this both before and after each STOP and counts strobes. Filter faults corrupt the stored byte of the glitched transfer and show at the first read of the outputs after that STOP.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef struct packed {
    logic       amp_on;
    logic       bass_en;
    logic       range_hi;
    logic [4:0] volume;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } xfer_st_t;

  localparam logic [5:0] ADDR_BASE = 6'b100110;
  localparam logic [7:0] CMD_RESET = 8'hFF;
endpackage

// File: rtl/hpc_line_filter.sv
module hpc_line_filter #(
  parameter int FILT_CYC = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC - 1);

  logic       s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LIMIT) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt = filt_q;

  // R10: the filtered level moves only after a full qualifying run
  a_r10_filter_run: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> ($past(cnt_q) == LIMIT));
endmodule

// File: rtl/hpc_bus_events.sv
module hpc_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic start,
  output logic stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start    = scl & scl_q & sda_q & ~sda;
  assign stop     = scl & scl_q & ~sda_q & sda;
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
endmodule

// File: rtl/hpc_xfer_fsm.sv
module hpc_xfer_fsm
  import hpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       addr_sel,
  input  logic       sda,
  input  logic       start,
  input  logic       stop,
  input  logic       scl_rise,
  input  logic       scl_fall,
  output logic       sda_pull,
  output logic       load,
  output logic [7:0] load_byte
);
  xfer_st_t   st_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, pend_q;
  logic       pend_v_q, pull_q, load_q;
  logic [6:0] my_addr;

  assign my_addr = {ADDR_BASE, addr_sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      pull_q   <= 1'b0;
      load_q   <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (stop) begin
        load_q   <= pend_v_q;
        pend_v_q <= 1'b0;
        pull_q   <= 1'b0;
        st_q     <= ST_IDLE;
      end else if (start) begin
        pend_v_q <= 1'b0;
        pull_q   <= 1'b0;
        bit_q    <= '0;
        st_q     <= ST_ADDR;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda};
              bit_q <= bit_q + 1'b1;
            end else if (scl_fall && bit_q == 4'd8) begin
              if (st_q == ST_DATA) begin
                pend_q   <= sh_q;
                pend_v_q <= 1'b1;
                pull_q   <= 1'b1;
                st_q     <= ST_DACK;
              end else if (sh_q[7:1] == my_addr && !sh_q[0]) begin
                pull_q <= 1'b1;
                st_q   <= ST_AACK;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              bit_q  <= '0;
              st_q   <= ST_DATA;
            end
          end
          ST_DACK: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              st_q   <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull  = pull_q;
  assign load      = load_q;
  assign load_byte = pend_q;

  // R2: SDA is pulled only inside an acknowledge slot
  a_r2_pull_in_ack: assert property (@(posedge clk) disable iff (rst)
    pull_q |-> (st_q == ST_AACK || st_q == ST_DACK));

  // R3: once skipping, the slave never pulls SDA
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SKIP && $past(st_q) == ST_SKIP) |-> !pull_q);

  // R9: a commit request follows a STOP only
  a_r9_load_after_stop: assert property (@(posedge clk) disable iff (rst)
    load_q |-> $past(stop));
endmodule

// File: rtl/hp_cmd_slave.sv
module hp_cmd_slave
  import hpc_pkg::*;
#(
  parameter int FILT_CYC = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  input  logic       shdn_n,
  output logic       sda_pull,
  output logic       amp_on,
  output logic       bass_en,
  output logic       range_hi,
  output logic [4:0] volume,
  output logic       dev_enable,
  output logic       commit
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_v, filt_v;
  logic start, stop, scl_rise, scl_fall;
  logic load;
  logic [7:0] load_byte;
  cmd_t cmd_q;
  logic commit_q, dev_q;

  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    hpc_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk (clk),
      .rst (rst),
      .raw (raw_v[g]),
      .filt(filt_v[g])
    );
  end

  hpc_bus_events u_evt (
    .clk     (clk),
    .rst     (rst),
    .scl     (filt_v[0]),
    .sda     (filt_v[1]),
    .start   (start),
    .stop    (stop),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  hpc_xfer_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .addr_sel (addr_sel),
    .sda      (filt_v[1]),
    .start    (start),
    .stop     (stop),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_pull (sda_pull),
    .load     (load),
    .load_byte(load_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= cmd_t'(CMD_RESET);
      commit_q <= 1'b0;
      dev_q    <= 1'b0;
    end else begin
      commit_q <= load;
      if (load) cmd_q <= cmd_t'(load_byte);
      dev_q <= shdn_n & cmd_q.amp_on;
    end
  end

  assign amp_on     = cmd_q.amp_on;
  assign bass_en    = cmd_q.bass_en;
  assign range_hi   = cmd_q.range_hi;
  assign volume     = cmd_q.volume;
  assign dev_enable = dev_q;
  assign commit     = commit_q;

  // R4: register moves only together with the strobe
  a_r4_update_with_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_q) |-> commit_q);

  // R4: strobe is a single cycle wide
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    commit_q |=> !commit_q);

  // R6: a low shutdown pin forces the device off
  a_r6_pin_off: assert property (@(posedge clk) disable iff (rst)
    $past(!shdn_n) |-> !dev_enable);
endmodule

// File: tb/hp_cmd_slave_tb.sv
module hp_cmd_slave_tb;
  localparam int Q = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic addr_sel = 1'b0, shdn_n = 1'b1;
  logic sda_pull, amp_on, bass_en, range_hi, dev_enable, commit;
  logic [4:0] volume;
  logic sda_bus;
  int n_chk = 0, n_bad = 0, n_commit = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_drv & ~sda_pull;

  hp_cmd_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_bus),
    .addr_sel(addr_sel), .shdn_n(shdn_n), .sda_pull(sda_pull),
    .amp_on(amp_on), .bass_en(bass_en), .range_hi(range_hi),
    .volume(volume), .dev_enable(dev_enable), .commit(commit)
  );

  always @(posedge clk) if (!rst && commit) n_commit++;

  function automatic logic [7:0] reg_now();
    return {amp_on, bass_en, range_hi, volume};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1; wq(); scl_drv = 1; wq(); sda_drv = 0; wq(); scl_drv = 0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 0; wq(); scl_drv = 1; wq(); sda_drv = 1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b; wq(); scl_drv = 1; wq(2 * Q); scl_drv = 0; wq();
  endtask

  task automatic get_ack(output logic ack);
    sda_drv = 1; wq(); scl_drv = 1; wq(); ack = sda_pull; wq(); scl_drv = 0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_ack(ack);
  endtask

  task automatic write_cmd(input logic [6:0] a, input logic rw, input logic [7:0] d,
                           output logic aa, output logic ad);
    bus_start();
    put_byte({a, rw}, aa);
    put_byte(d, ad);
    bus_stop();
  endtask

  task automatic t_reset();
    wq(10);
    chk("R1 reg", reg_now(), 8'hFF);
    chk("R1 pull", sda_pull, 0);
    chk("R1 commits", n_commit, 0);
    chk("R6 dev_enable reset", dev_enable, 1);
  endtask

  task automatic t_basic();
    logic aa, ad; int c0;
    c0 = n_commit;
    bus_start();
    put_byte({7'b1001100, 1'b0}, aa);
    put_byte(8'h95, ad);
    chk("R2 ack addr 4C", aa, 1);
    chk("R4 ack data", ad, 1);
    chk("R4 held before stop", reg_now(), 8'hFF);
    chk("R4 no strobe before stop", n_commit, c0);
    bus_stop();
    chk("R4 strobe count", n_commit, c0 + 1);
    chk("R5 amp_on", amp_on, 1);
    chk("R5 bass_en", bass_en, 0);
    chk("R5 range_hi", range_hi, 0);
    chk("R5 volume", volume, 5'h15);
  endtask

  task automatic t_addr_sel();
    logic aa, ad;
    addr_sel = 1; wq();
    write_cmd(7'b1001100, 0, 8'h11, aa, ad);
    chk("R3 mismatch nack", aa, 0);
    chk("R3 mismatch data nack", ad, 0);
    chk("R3 mismatch unchanged", reg_now(), 8'h95);
    write_cmd(7'b1001101, 0, 8'h60, aa, ad);
    chk("R2 ack addr 4D", aa, 1);
    chk("R2 stored 4D", reg_now(), 8'h60);
    wq(4);
    chk("R6 off by bit7", dev_enable, 0);
  endtask

  task automatic t_read();
    logic aa, ad;
    write_cmd(7'b1001101, 1, 8'hE7, aa, ad);
    chk("R3 read nack", aa, 0);
    chk("R3 read data nack", ad, 0);
    chk("R3 read unchanged", reg_now(), 8'h60);
  endtask

  task automatic t_shutdown();
    logic aa, ad;
    shdn_n = 0; wq();
    write_cmd(7'b1001101, 0, 8'hC3, aa, ad);
    chk("R7 ack in shutdown", ad, 1);
    chk("R7 stored in shutdown", reg_now(), 8'hC3);
    chk("R6 pin low", dev_enable, 0);
    shdn_n = 1; wq(4);
    chk("R6 both high", dev_enable, 1);
  endtask

  task automatic t_partial();
    logic aa, ad; int c0;
    c0 = n_commit;
    bus_start();
    put_byte({7'b1001101, 1'b0}, aa);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk("R8 stop partial unchanged", reg_now(), 8'hC3);
    chk("R8 stop partial no strobe", n_commit, c0);
    bus_start();
    put_byte({7'b1001101, 1'b0}, aa);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    bus_start();
    put_byte({7'b1001101, 1'b0}, aa);
    put_byte(8'h8A, ad);
    bus_stop();
    chk("R8 restart partial then write", reg_now(), 8'h8A);
    chk("R8 single strobe", n_commit, c0 + 1);
  endtask

  task automatic t_restart_pending();
    logic aa, ad;
    bus_start();
    put_byte({7'b1001101, 1'b0}, aa);
    put_byte(8'h12, ad);
    bus_start();
    put_byte({7'b1001100, 1'b0}, aa);
    bus_stop();
    chk("R11 pending dropped by restart", reg_now(), 8'h8A);
    bus_start();
    put_byte({7'b1001101, 1'b0}, aa);
    put_byte(8'h34, ad);
    bus_start();
    put_byte({7'b1001101, 1'b0}, aa);
    put_byte(8'hB7, ad);
    bus_stop();
    chk("R11 last byte wins", reg_now(), 8'hB7);
  endtask

  task automatic t_extra();
    logic aa, ad, a2;
    bus_start();
    put_byte({7'b1001101, 1'b0}, aa);
    put_byte(8'h81, ad);
    put_byte(8'h7E, a2);
    bus_stop();
    chk("R9 second byte nack", a2, 0);
    chk("R9 first byte kept", reg_now(), 8'h81);
  endtask

  task automatic t_mute();
    logic aa, ad;
    write_cmd(7'b1001101, 0, 8'h80, aa, ad);
    chk("R5 mute volume", volume, 0);
  endtask

  task automatic t_glitch();
    logic aa, ad;
    logic [7:0] d = 8'hA5;
    bus_start();
    put_byte({7'b1001101, 1'b0}, aa);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = d[i]; wq(20);
      scl_drv = 1; wq(15); scl_drv = 0;
      wq(Q - 35);
      scl_drv = 1; wq(30);
      sda_drv = ~d[i]; wq(15); sda_drv = d[i];
      wq(2 * Q - 45);
      scl_drv = 0; wq();
    end
    get_ack(ad);
    bus_stop();
    chk("R10 ack despite glitches", ad, 1);
    chk("R10 byte intact", reg_now(), 8'hA5);
  endtask

  initial begin
    wq(8);
    rst = 0;
    t_reset();
    t_basic();
    t_addr_sel();
    t_read();
    t_shutdown();
    t_partial();
    t_restart_pending();
    t_extra();
    t_mute();
    t_glitch();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule